// File: doc/BRIEF.md
# Serial-Fixing Three-Weight Scan Pattern Generator

This block feeds the serial input of a scan chain during self-test. Each bit it shifts in is either forced to 0, forced to 1, or taken from a pseudorandom source, which gives it a weight of 0.5. Which of the three applies to a given scan position depends on the active weight set. Several weight sets are fixed by parameters. The block applies a configured number of patterns with each weight set, one set after another. After the last pattern has been captured, it reports completion.

The forcing is done by a pair of toggle flip-flops that drive an AND gate and an OR gate on the pseudorandom bit. The weights are never read from a per-position stored vector. The toggle flip-flops change state only when decode logic fires. That logic looks at the scan position counter and at the weight-set index, which is the upper part of the pattern counter. At the start of every pattern, the flip-flops are loaded with the state that scan position 0 of the active set needs.

A pulse on the start input begins a run. Each pattern takes one shift cycle per scan cell and then one capture cycle in which shifting stops.

Top module: `tw_scan_gen`

## Requirements
- R1: After reset, shift_en, scan_in and done are all 0 and stay 0 until a start is seen.
- R2: A start sampled while no run is active begins a run. The next cycle is the first shift of pattern 0 at scan position 0, and the pseudorandom register is reloaded with LFSR_SEED.
- R3: Each pattern is SCAN_LEN shift cycles (shift_en=1) followed by exactly one capture cycle (shift_en=0). The k-th shift cycle of a pattern, counting from 0, carries the value for scan position k.
- R4: Weight set g fixes position k when bit g*SCAN_LEN+k of GEN_MASK is 1. If the matching bit of GEN_VAL is 0, scan_in is 0 at that position.
- R5: At a fixed position whose GEN_VAL bit is 1, scan_in is 1.
- R6: At a free position (GEN_MASK bit 0), scan_in equals bit LFSR_W-1 of the pseudorandom register. On every shift cycle, and only then, that register shifts toward its MSB and takes as its new bit 0 the XOR of the register ANDed with LFSR_TAPS.
- R7: Pattern p of a run, counting from 0, uses weight set p / PATS_PER_GEN. A run has NUM_GEN*PATS_PER_GEN patterns.
- R8: After the capture cycle of the last pattern, done is 1 and shift_en and scan_in are 0. This holds until a new start.
- R9: A start that arrives while a run is active has no effect on the output sequence.
- R10: The two fixing flip-flops change only when the decode logic fires or when a pattern is loaded. On every shift cycle they hold the controls that the current position needs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when no run is active |
| scan_in | output | 1 | Serial bit for the scan chain input |
| shift_en | output | 1 | High on shift cycles, low on capture and when not running |
| done | output | 1 | High once every pattern has been applied |

## Verification
A fixing flip-flop in the wrong state shows up at the very next shift cycle whose position is fixed. The bit carries the wrong constant, or a random bit appears where a constant belongs. The weight sets used in the bench mix fixed and free runs in several orders, and some sets fix position 0 while others leave it free, so a wrong load or a missed toggle reaches scan_in within one pattern. A scan or pattern counter that is off by one moves the capture gap or the weight-set boundary, so shift_en or the weight pattern goes wrong within SCAN_LEN+1 cycles. A skipped or duplicated pseudorandom step corrupts every free bit that follows it.

// File: rtl/tw_scan_gen_pkg.sv
package tw_scan_gen_pkg;

  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_RUN  = 2'd1,
    RS_DONE = 2'd2
  } run_state_t;

  typedef struct packed {
    logic force_one;   // drives the OR gate
    logic force_zero;  // drives the AND gate (inverted)
  } fix_ctl_t;

endpackage

// File: rtl/tw_lfsr.sv
module tw_lfsr #(
  parameter int              WIDTH = 16,
  parameter logic [WIDTH-1:0] TAPS = 16'hB400,
  parameter logic [WIDTH-1:0] SEED = 16'hACE1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reload,
  input  logic advance,
  output logic rnd_bit
);

  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;
  logic             state_en;

  always_comb begin
    state_en = reload | advance;
    if (reload) state_d = SEED;
    else        state_d = {state_q[WIDTH-2:0], ^(state_q & TAPS)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= SEED;
    else if (state_en) state_q <= state_d;
  end

  assign rnd_bit = state_q[WIDTH-1];

  // R6: a maximal feedback never reaches the all-zero lockup state
  a_r6_lfsr_not_stuck: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

endmodule

// File: rtl/tw_sequencer.sv
module tw_sequencer
  import tw_scan_gen_pkg::*;
#(
  parameter int SCAN_LEN     = 16,
  parameter int NUM_GEN      = 4,
  parameter int PATS_PER_GEN = 4,
  localparam int CNT_W = $clog2(SCAN_LEN + 1),
  localparam int GEN_W = $clog2(NUM_GEN),
  localparam int VEC_W = $clog2(NUM_GEN * PATS_PER_GEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic [CNT_W-1:0] scan_cnt,
  output logic [GEN_W-1:0] gen_idx,
  output logic [GEN_W-1:0] load_gen,
  output logic             pat_load,
  output logic             shifting,
  output logic             done
);

  localparam logic [CNT_W-1:0] CAP_SLOT = CNT_W'(SCAN_LEN);
  localparam logic [VEC_W-1:0] LAST_VEC = '1;

  run_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             launch, capture, last_pat, seq_en;

  always_comb begin
    launch   = (state_q != RS_RUN) && start;
    capture  = (state_q == RS_RUN) && (cnt_q == CAP_SLOT);
    last_pat = (vec_q == LAST_VEC);
    seq_en   = launch || (state_q == RS_RUN);
    state_d  = state_q;
    cnt_d    = cnt_q;
    vec_d    = vec_q;
    if (launch) begin
      state_d = RS_RUN;
      cnt_d   = '0;
      vec_d   = '0;
    end else if (capture) begin
      cnt_d = '0;
      if (last_pat) state_d = RS_DONE;
      else          vec_d   = vec_q + 1'b1;
    end else if (state_q == RS_RUN) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_IDLE;
      cnt_q   <= '0;
      vec_q   <= '0;
    end else if (seq_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      vec_q   <= vec_d;
    end
  end

  always_comb begin
    scan_cnt = cnt_q;
    gen_idx  = vec_q[VEC_W-1 -: GEN_W];
    pat_load = launch || (capture && !last_pat);
    load_gen = launch ? '0 : vec_d[VEC_W-1 -: GEN_W];
    shifting = (state_q == RS_RUN) && (cnt_q != CAP_SLOT);
    done     = (state_q == RS_DONE);
  end

  // R3: the position counter never passes the capture slot
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CAP_SLOT);
  // R3: a capture that is not the last is followed by position 0 of a new pattern
  a_r3_capture_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !last_pat) |=> (shifting && scan_cnt == '0));
  // R8: done holds until a new start
  a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && !shifting));
  // R9: a start during a shift cycle does not disturb the count
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (shifting && start) |=> (state_q == RS_RUN && cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/tw_decode.sv
module tw_decode
  import tw_scan_gen_pkg::*;
#(
  parameter int SCAN_LEN = 16,
  parameter int NUM_GEN  = 4,
  parameter logic [NUM_GEN*SCAN_LEN-1:0] GEN_MASK = '0,
  parameter logic [NUM_GEN*SCAN_LEN-1:0] GEN_VAL  = '0,
  localparam int CNT_W = $clog2(SCAN_LEN + 1),
  localparam int GEN_W = $clog2(NUM_GEN),
  localparam int TAB_N = NUM_GEN * SCAN_LEN,
  localparam int IDX_W = $clog2(TAB_N)
) (
  input  logic [CNT_W-1:0] scan_cnt,
  input  logic [GEN_W-1:0] gen_idx,
  input  logic [GEN_W-1:0] load_gen,
  input  logic             shifting,
  output logic             d0,
  output logic             d1,
  output fix_ctl_t         init_ctl,
  output fix_ctl_t         want_ctl
);

  // Control state required at position k of weight set g; when forcing a one
  // the zero-force line is a don't-care, so it keeps its previous value.
  function automatic logic [1:0] pos_state(int g, int k);
    logic f0, f1;
    f0 = 1'b0;
    f1 = 1'b0;
    for (int i = 0; i <= k; i++) begin
      if (GEN_MASK[g*SCAN_LEN+i]) begin
        if (GEN_VAL[g*SCAN_LEN+i]) f1 = 1'b1;
        else begin
          f1 = 1'b0;
          f0 = 1'b1;
        end
      end else begin
        f0 = 1'b0;
        f1 = 1'b0;
      end
    end
    return {f1, f0};
  endfunction

  logic [TAB_N-1:0] st0_tab, st1_tab, tg0_tab, tg1_tab;

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_set
    for (genvar k = 0; k < SCAN_LEN; k++) begin : g_pos
      localparam logic [1:0] CUR = pos_state(g, k);
      localparam logic [1:0] NXT = pos_state(g, (k < SCAN_LEN-1) ? k+1 : k);
      assign st0_tab[g*SCAN_LEN+k] = CUR[0];
      assign st1_tab[g*SCAN_LEN+k] = CUR[1];
      assign tg0_tab[g*SCAN_LEN+k] = CUR[0] ^ NXT[0];
      assign tg1_tab[g*SCAN_LEN+k] = CUR[1] ^ NXT[1];
    end
  end

  logic [CNT_W-1:0] cnt_clip;
  logic [IDX_W-1:0] cur_idx, init_idx;
  logic             cur_valid;

  always_comb begin
    cur_valid = shifting && (scan_cnt < CNT_W'(SCAN_LEN));
    cnt_clip  = cur_valid ? scan_cnt : '0;
    cur_idx   = IDX_W'(gen_idx) * IDX_W'(SCAN_LEN) + IDX_W'(cnt_clip);
    init_idx  = IDX_W'(load_gen) * IDX_W'(SCAN_LEN);
    d0        = cur_valid && tg0_tab[cur_idx];
    d1        = cur_valid && tg1_tab[cur_idx];
    init_ctl.force_zero = st0_tab[init_idx];
    init_ctl.force_one  = st1_tab[init_idx];
    want_ctl.force_zero = st0_tab[cur_idx];
    want_ctl.force_one  = st1_tab[cur_idx];
  end

endmodule

// File: rtl/tw_fix.sv
module tw_fix
  import tw_scan_gen_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  fix_ctl_t init_ctl,
  input  logic     d0,
  input  logic     d1,
  input  logic     shifting,
  input  logic     rnd_bit,
  output fix_ctl_t ctl,
  output logic     bit_out
);

  logic f0_q, f1_q, f0_d, f1_d, f0_en, f1_en;

  always_comb begin
    f0_en = load | d0;
    f1_en = load | d1;
    f0_d  = load ? init_ctl.force_zero : ~f0_q;
    f1_d  = load ? init_ctl.force_one  : ~f1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     f0_q <= 1'b0;
    else if (f0_en) f0_q <= f0_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     f1_q <= 1'b0;
    else if (f1_en) f1_q <= f1_d;
  end

  always_comb begin
    ctl.force_zero = f0_q;
    ctl.force_one  = f1_q;
    bit_out        = shifting & ((rnd_bit & ~f0_q) | f1_q);
  end

endmodule

// File: rtl/tw_scan_gen.sv
module tw_scan_gen
  import tw_scan_gen_pkg::*;
#(
  parameter int SCAN_LEN     = 16,
  parameter int NUM_GEN      = 4,
  parameter int PATS_PER_GEN = 4,
  parameter int LFSR_W       = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  parameter logic [NUM_GEN*SCAN_LEN-1:0] GEN_MASK = 64'hF0F0_00FF_FFFF_0000,
  parameter logic [NUM_GEN*SCAN_LEN-1:0] GEN_VAL  = 64'h6090_0033_A5C3_0000,
  localparam int CNT_W = $clog2(SCAN_LEN + 1),
  localparam int GEN_W = $clog2(NUM_GEN)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic scan_in,
  output logic shift_en,
  output logic done
);

  logic [CNT_W-1:0] scan_cnt;
  logic [GEN_W-1:0] gen_idx, load_gen;
  logic             pat_load, shifting, rnd_bit, d0, d1, lfsr_reload;
  fix_ctl_t         init_ctl, want_ctl, ctl;

  assign lfsr_reload = pat_load && !shifting && !(scan_cnt == CNT_W'(SCAN_LEN));

  tw_sequencer #(
    .SCAN_LEN(SCAN_LEN), .NUM_GEN(NUM_GEN), .PATS_PER_GEN(PATS_PER_GEN)
  ) i_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .scan_cnt(scan_cnt), .gen_idx(gen_idx), .load_gen(load_gen),
    .pat_load(pat_load), .shifting(shifting), .done(done)
  );

  tw_lfsr #(.WIDTH(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) i_lfsr (
    .clk(clk), .rst_n(rst_n), .reload(lfsr_reload),
    .advance(shifting), .rnd_bit(rnd_bit)
  );

  tw_decode #(
    .SCAN_LEN(SCAN_LEN), .NUM_GEN(NUM_GEN), .GEN_MASK(GEN_MASK), .GEN_VAL(GEN_VAL)
  ) i_dec (
    .scan_cnt(scan_cnt), .gen_idx(gen_idx), .load_gen(load_gen),
    .shifting(shifting), .d0(d0), .d1(d1),
    .init_ctl(init_ctl), .want_ctl(want_ctl)
  );

  tw_fix i_fix (
    .clk(clk), .rst_n(rst_n), .load(pat_load), .init_ctl(init_ctl),
    .d0(d0), .d1(d1), .shifting(shifting), .rnd_bit(rnd_bit),
    .ctl(ctl), .bit_out(scan_in)
  );

  assign shift_en = shifting;

  // R10: on every shift cycle the toggle state matches the position's weight
  a_r10_ctl_tracks_weight: assert property (@(posedge clk) disable iff (!rst_n)
    shifting |-> (ctl.force_one == want_ctl.force_one &&
                  (want_ctl.force_one || ctl.force_zero == want_ctl.force_zero)));
  // R10: the zero-force line changes only on a decode toggle or a pattern load
  a_r10_zero_line_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!pat_load && !d0) |=> $stable(ctl.force_zero));
  // R8: nothing is shifted once the run is complete
  a_r8_no_shift_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!shift_en && !scan_in));

endmodule

// File: tb/test_tw_scan_gen.sv
module test_tw_scan_gen;

  localparam int M   = 8;
  localparam int NG  = 4;
  localparam int PPG = 2;
  localparam int LW  = 16;
  localparam logic [LW-1:0] TAPS = 16'hB400;
  localparam logic [LW-1:0] SEED = 16'h1D2B;
  // sets from 3 down to 0; bit k of each byte is scan position k
  localparam logic [NG*M-1:0] MASK = {8'h5A, 8'hF0, 8'hFF, 8'h00};
  localparam logic [NG*M-1:0] VALS = {8'h12, 8'h60, 8'hA5, 8'h00};
  localparam int NPAT = NG * PPG;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic scan_in, shift_en, done;

  always #4 clk = ~clk;

  tw_scan_gen #(
    .SCAN_LEN(M), .NUM_GEN(NG), .PATS_PER_GEN(PPG), .LFSR_W(LW),
    .LFSR_TAPS(TAPS), .LFSR_SEED(SEED), .GEN_MASK(MASK), .GEN_VAL(VALS)
  ) i_tw_scan_gen (
    .clk(clk), .rst_n(rst_n), .start(start),
    .scan_in(scan_in), .shift_en(shift_en), .done(done)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // bench reference state
  int          m_state = 0;  // 0 idle, 1 run, 2 done
  int          m_cnt   = 0;
  int          m_pat   = 0;
  logic [LW-1:0] m_lfsr = SEED;
  logic        m_ign   = 1'b0;

  task automatic chk(input logic got, input logic exp, input string req);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic lfsr_step_bit(input logic [LW-1:0] s);
    return ^(s & TAPS);
  endfunction

  // compare outputs against the reference (at negedge)
  task automatic compare(input string ctx);
    int g;
    string tag;
    if (m_state == 1) begin
      chk(shift_en, (m_cnt < M), $sformatf("R3 %s shift_en pat %0d pos %0d", ctx, m_pat, m_cnt));
      chk(done, 1'b0, "R8 done low while running");
      if (m_cnt < M) begin
        g = m_pat / PPG;
        if (MASK[g*M+m_cnt]) tag = VALS[g*M+m_cnt] ? "R5" : "R4";
        else                 tag = "R6";
        // R10: a stale fixing flip-flop shows here as a wrong bit
        chk(scan_in,
            MASK[g*M+m_cnt] ? VALS[g*M+m_cnt] : m_lfsr[LW-1],
            $sformatf("R7/%s %s set %0d pat %0d pos %0d", tag, ctx, g, m_pat, m_cnt));
      end else begin
        chk(scan_in, 1'b0, "R3 scan_in low on capture");
      end
    end else if (m_state == 2) begin
      chk(done, 1'b1, "R8 done");
      chk(shift_en, 1'b0, "R8 shift_en");
      chk(scan_in, 1'b0, "R8 scan_in");
    end else begin
      chk(done, 1'b0, "R1 done idle");
      chk(shift_en, 1'b0, "R1 shift_en idle");
      chk(scan_in, 1'b0, "R1 scan_in idle");
    end
  endtask

  // advance the reference across one rising edge given the start level
  task automatic model_edge(input logic st);
    if (m_state != 1 && st) begin
      m_state = 1; m_cnt = 0; m_pat = 0; m_lfsr = SEED;
    end else if (m_state == 1) begin
      if (m_cnt < M) begin
        m_lfsr = {m_lfsr[LW-2:0], lfsr_step_bit(m_lfsr)};
        m_cnt++;
      end else if (m_pat == NPAT - 1) begin
        m_state = 2;
      end else begin
        m_pat++; m_cnt = 0;
      end
    end
  endtask

  task automatic cycle(input logic st, input string ctx);
    start = st;
    @(posedge clk);
    model_edge(st);
    @(negedge clk);
    compare(ctx);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    // R1: reset state
    @(negedge clk); compare("R1 in reset");
    @(negedge clk); compare("R1 in reset");
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) cycle(1'b0, "R1 idle");

    // directed run: R2 launch then full sequence, no stray starts
    cycle(1'b1, "R2 launch");
    for (int i = 0; i < NPAT*(M+1) + 2; i++) cycle(1'b0, "R2 run");

    // R8: done stays until a new start
    for (int i = 0; i < 4; i++) cycle(1'b0, "R8 hold");

    // random runs with R9 stray starts
    for (int r = 0; r < 4; r++) begin
      int gap;
      gap = $urandom_range(0, 5);
      for (int i = 0; i < gap; i++) cycle(1'b0, "gap");
      cycle(1'b1, "R2 relaunch");
      for (int i = 0; i < NPAT*(M+1) + 1; i++) begin
        logic st;
        st = ($urandom_range(0, 7) == 0);
        // a start on the final cycle is a legal relaunch; keep it off there
        if (i == NPAT*(M+1) - 1 || i == NPAT*(M+1)) st = 1'b0;
        cycle(st, st ? "R9 stray start" : "R9 run");
      end
    end

    // directed: start held high across completion relaunches at once (R2)
    cycle(1'b1, "R2 held start");
    for (int i = 0; i < NPAT*(M+1) + 3; i++) cycle(1'b1, "R9 held start");
    cycle(1'b0, "R2 tail");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule